// File: doc/BRIEF.md
# Configurable Victim-Set Crossover Mapper

This block decides, for each of the sixteen links of a 4×4 inter-die link array, whether the link carries the victim pattern or the aggressor pattern during an interconnect test. A one-hot shift counter walks through the victim sets one at a time. A crossover switch then routes one counter position to each link's role output. Which position feeds which link depends on the aggressor order chosen, so one piece of hardware can run test sequences for more than one crosstalk neighbourhood size.

Two orders are supported. Order one splits the array into two victim sets, and order two splits it into six. A small decoder turns the order code into two things. The first is the number of active counter positions. The second is a one-hot select vector per link that names the counter position driving it. The mapping is a fixed table and is not computed at run time. The order code is expected to stay constant while a test phase runs, which keeps the decode out of the per-cycle test path.

A test-sequence controller pulses `start` to point the counter at the first set. It pulses `shift` after finishing the patterns for the current set, and watches `done` to learn that the last active set has been reached.

Top module: `vsx_mapper`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `cnt_pos` is all zero, `role_b` is all zero and `done` is low.
- R2: Order code 2'd1 selects order one and makes `set_count` = 2. Order code 2'd2 selects order two and makes `set_count` = 6. The unsupported codes 2'd0 and 2'd3 fall back to order two (`set_count` = 6).
- R3: A cycle with `start` high loads `cnt_pos` with 6'b000001 (victim set 1) on the next edge, whatever the counter held and whatever `shift` is. `cnt_pos` is always zero or one-hot.
- R4: When `start` is low, `shift` is high, the counter is non-zero and `done` is low, the one-hot bit moves up by exactly one position on the next edge. When the counter is zero and `start` is low, it stays zero whatever `shift` does.
- R5: `done` is high exactly when the one-hot bit sits at position `set_count` (bit index `set_count`-1 of `cnt_pos`).
- R6: While `done` is high and `start` is low, `shift` has no effect: `cnt_pos` keeps its value.
- R7: Under order one, links 1,3,6,8,9,11,14,16 follow set 1 and links 2,4,5,7,10,12,13,15 follow set 2. Link n is bit n-1 of `role_b`, and a 1 means victim.
- R8: Under order two, links 1..16 follow sets 1,2,3,1,3,4,5,2,2,1,6,3,4,3,2,1 in that order.
- R9: Each link has exactly one active position select. `role_b[n-1]` is 1 exactly when the counter's one-hot bit is at that link's set for the current order.
- R10: While the counter is zero, every link is an aggressor (`role_b` all zero).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| order_code | input | 2 | Aggressor order selection, held constant during a test phase |
| start | input | 1 | Point the counter at victim set 1 |
| shift | input | 1 | Advance to the next victim set |
| cnt_pos | output | 6 | One-hot active victim set, bit 0 = set 1 |
| role_b | output | 16 | Per-link role, 1 = victim, bit 0 = link 1 |
| set_count | output | 3 | Number of victim sets for the decoded order |
| done | output | 1 | Last active set reached |

## Verification
The bench targets the last active position. A counter that ignored `set_count` would run past set 2 under order one. One that let `shift` through in the done state would push the bit off the active range or out of the register entirely. The fallback codes are exercised so that a decoder that treated them as order one, or as no order, would show the wrong set count and the wrong link roles. Every link is compared with its table entry at every position under both orders, which catches a single misrouted crossover select. Restarts in mid-sequence and shifts while idle check that `start` takes priority and that an idle counter cannot be made to leave zero.

// File: rtl/vsx_pkg.sv
package vsx_pkg;

    localparam int N_LINK = 16;
    localparam int W_MAX  = 6;
    localparam int POS_W  = $clog2(W_MAX + 1);

    typedef enum logic {
        ORDER_ONE = 1'b0,
        ORDER_TWO = 1'b1
    } order_e;

    typedef struct packed {
        order_e           ord;
        logic [POS_W-1:0] sets;
    } cfg_t;

    // Unsupported codes fall back to the highest supported order
    function automatic order_e decode_order(input logic [1:0] code);
        return (code == 2'd1) ? ORDER_ONE : ORDER_TWO;
    endfunction

    function automatic logic [POS_W-1:0] sets_of(input order_e o);
        return (o == ORDER_ONE) ? POS_W'(2) : POS_W'(6);
    endfunction

    // Zero-based counter position that drives zero-based link index
    function automatic int unsigned pos_of(input order_e o, input int unsigned link);
        logic [15:0] first_set_mask;
        int unsigned p;
        first_set_mask = 16'hA5A5;
        if (o == ORDER_ONE) begin
            p = first_set_mask[link[3:0]] ? 0 : 1;
        end else begin
            case (link)
                0, 3, 9, 15:   p = 0;
                1, 7, 8, 14:   p = 1;
                2, 4, 11, 13:  p = 2;
                5, 12:         p = 3;
                6:             p = 4;
                default:       p = 5;
            endcase
        end
        return p;
    endfunction

endpackage

// File: rtl/vsx_cfg_decode.sv
module vsx_cfg_decode
    import vsx_pkg::*;
#(
    parameter int N = N_LINK,
    parameter int W = W_MAX,
    parameter int PW = POS_W
) (
    input  logic [1:0]          order_code,
    output logic [PW-1:0]       sets,
    output logic [N-1:0][W-1:0] sel
);
    cfg_t cfg;

    always_comb begin
        cfg.ord  = decode_order(order_code);
        cfg.sets = sets_of(cfg.ord);
    end

    assign sets = cfg.sets;

    for (genvar j = 0; j < N; j++) begin : g_link
        always_comb begin
            sel[j] = '0;
            sel[j][pos_of(cfg.ord, j)] = 1'b1;
        end
    end
endmodule

// File: rtl/vsx_shift_counter.sv
module vsx_shift_counter
    import vsx_pkg::*;
#(
    parameter int W = W_MAX,
    parameter int PW = POS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          shift,
    input  logic [PW-1:0] sets,
    output logic [W-1:0]  cnt,
    output logic          done
);
    logic [W-1:0] last_mask;

    always_comb begin
        last_mask = W'(1) << (sets - PW'(1));
        done      = |(cnt & last_mask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= W'(1);
        end else if (shift && (cnt != '0) && !done) begin
            cnt <= cnt << 1;
        end
    end

    AST_START_LOAD: assert property (@(posedge clk) disable iff (rst)
        start |=> (cnt == W'(1)));                                        // R3
    AST_CNT_ONEHOT0: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cnt));                                                   // R3
    AST_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (!start && shift && (cnt != '0) && !done) |=> (cnt == ($past(cnt) << 1))); // R4
    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst)
        (!start && (cnt == '0)) |=> (cnt == '0));                         // R4
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!start && done) |=> $stable(cnt));                               // R6
endmodule

// File: rtl/vsx_crossover.sv
module vsx_crossover
    import vsx_pkg::*;
#(
    parameter int N = N_LINK,
    parameter int W = W_MAX
) (
    input  logic [N-1:0][W-1:0] sel,
    input  logic [W-1:0]        cnt,
    output logic [N-1:0]        role
);
    for (genvar j = 0; j < N; j++) begin : g_sw
        assign role[j] = |(sel[j] & cnt);
    end
endmodule

// File: rtl/vsx_mapper.sv
module vsx_mapper
    import vsx_pkg::*;
#(
    parameter int N = N_LINK,
    parameter int W = W_MAX,
    parameter int PW = POS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    order_code,
    input  logic          start,
    input  logic          shift,
    output logic [W-1:0]  cnt_pos,
    output logic [N-1:0]  role_b,
    output logic [PW-1:0] set_count,
    output logic          done
);
    logic [N-1:0][W-1:0] sel;

    vsx_cfg_decode #(.N(N), .W(W), .PW(PW)) u_decode (
        .order_code (order_code),
        .sets       (set_count),
        .sel        (sel)
    );

    vsx_shift_counter #(.W(W), .PW(PW)) u_counter (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .shift (shift),
        .sets  (set_count),
        .cnt   (cnt_pos),
        .done  (done)
    );

    vsx_crossover #(.N(N), .W(W)) u_xbar (
        .sel  (sel),
        .cnt  (cnt_pos),
        .role (role_b)
    );

    for (genvar j = 0; j < N; j++) begin : g_chk
        AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
            $onehot(sel[j]));                                             // R9
    end

    AST_IDLE_ROLES: assert property (@(posedge clk) disable iff (rst)
        (cnt_pos == '0) |-> (role_b == '0));                              // R10
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> ((cnt_pos == '0) && !done));                              // R1
endmodule

// File: tb/vsx_mapper_bench.sv
module vsx_mapper_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  order_code = 2'd1;
    logic        start = 1'b0;
    logic        shift = 1'b0;
    logic [5:0]  cnt_pos;
    logic [15:0] role_b;
    logic [2:0]  set_count;
    logic        done;

    int tests = 0;
    int fails = 0;
    int exp_pos = 0;

    always #4 clk = ~clk;

    vsx_mapper u_vsx_mapper (
        .clk(clk), .rst(rst), .order_code(order_code), .start(start),
        .shift(shift), .cnt_pos(cnt_pos), .role_b(role_b),
        .set_count(set_count), .done(done)
    );

    function automatic int exp_sets(input logic [1:0] c);
        return (c == 2'd1) ? 2 : 6;
    endfunction

    // One-based victim set of one-based link, from R7 / R8
    function automatic int link_set(input logic [1:0] c, input int link);
        if (c == 2'd1) begin
            case (link)
                1, 3, 6, 8, 9, 11, 14, 16: return 1;
                default: return 2;
            endcase
        end
        case (link)
            1: return 1;  2: return 2;  3: return 3;  4: return 1;
            5: return 3;  6: return 4;  7: return 5;  8: return 2;
            9: return 2;  10: return 1; 11: return 6; 12: return 3;
            13: return 4; 14: return 3; 15: return 2; default: return 1;
        endcase
    endfunction

    function automatic logic [15:0] exp_roles(input logic [1:0] c, input int p);
        logic [15:0] r = '0;
        for (int n = 1; n <= 16; n++)
            r[n-1] = (p != 0) && (link_set(c, n) == p);
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_all();
        logic [5:0] ecnt;
        ecnt = (exp_pos == 0) ? 6'd0 : (6'd1 << (exp_pos - 1));
        check("R2 set_count", 32'(set_count), 32'(exp_sets(order_code)));
        check("R4 cnt_pos", 32'(cnt_pos), 32'(ecnt));
        check("R5 done", 32'(done), 32'(exp_pos == exp_sets(order_code)));
        if (exp_pos == 0)
            check("R10 roles idle", 32'(role_b), 32'h0);
        else if (order_code == 2'd1)
            check("R7 roles order one", 32'(role_b), 32'(exp_roles(order_code, exp_pos)));
        else
            check("R8 roles order two", 32'(role_b), 32'(exp_roles(order_code, exp_pos)));
    endtask

    task automatic cyc(input logic s, input logic sh);
        @(negedge clk);
        start = s;
        shift = sh;
        @(posedge clk);
        #1;
        if (s) exp_pos = 1;
        else if (sh && exp_pos != 0 && exp_pos != exp_sets(order_code)) exp_pos++;
        check_all();
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4177));
        repeat (3) @(posedge clk);
        #1;
        check("R1 cnt_pos in reset", 32'(cnt_pos), 32'h0);
        check("R1 roles in reset", 32'(role_b), 32'h0);
        check("R1 done in reset", 32'(done), 32'h0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R1 cnt_pos after reset", 32'(cnt_pos), 32'h0);

        // R4: shift while idle must not leave zero
        cyc(1'b0, 1'b1);
        cyc(1'b0, 1'b1);

        // Directed full sweeps for every code incl. fallbacks (R2, R7, R8, R9)
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            order_code = 2'(c);
            cyc(1'b1, 1'b1);             // R3 start wins over shift
            check("R3 loads set 1", 32'(cnt_pos), 32'h1);
            for (int s = 0; s < 7; s++) cyc(1'b0, 1'b1);  // R6 extra shifts at done
            check("R6 held at last set", 32'(cnt_pos), 32'(6'd1 << (exp_sets(2'(c)) - 1)));
        end

        // R3: restart in the middle of a run
        @(negedge clk);
        order_code = 2'd2;
        cyc(1'b1, 1'b0);
        cyc(1'b0, 1'b1);
        cyc(1'b0, 1'b1);
        cyc(1'b1, 1'b0);
        check("R3 restart mid-run", 32'(cnt_pos), 32'h1);

        // Random runs
        for (int run = 0; run < 60; run++) begin
            @(negedge clk);
            order_code = 2'($urandom % 4);
            cyc(1'b1, 1'($urandom % 2));
            for (int k = 0; k < 25; k++)
                cyc(1'(($urandom % 16) == 0), 1'($urandom % 2));
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule